// File: doc/BRIEF.md
# Successive-Approximation Converter Control Logic

This block is the digital half of a 16-bit successive-approximation analog-to-digital converter. A host asks for a conversion by pulling an active-low start line low while its active-low select line is low. The block leaves sampling for hold at once, raises a busy flag, and then runs a binary search over the output code. Each trial code goes to the capacitor DAC, and a single comparator bit comes back. One bit is decided on each rising edge of the conversion clock, from the most significant bit down to the least.

When the last bit is decided, busy drops and the finished code is copied into an output latch. The latched code is presented on a parallel data bus. The bus is driven only while select and read are both low, and is released otherwise. A byte-lane select lets an 8-bit host fetch the code in two reads on the low eight lines. The lane select acts without any clock, so read may stay low while it changes.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A falling edge of `start_n` seen while `cs_n` is high is discarded: busy stays low and the latched result keeps its value.
- R2: When `start_n` falls with `cs_n` low and no conversion is running, `busy` and `hold` go high in the same cycle, before the next clock edge.
- R3: A conversion starts at the first rising clock edge after the accepted fall of `start_n`. Busy stays high through the next 15 rising edges and is low after the 16th.
- R4: The result is straight binary and equals the largest code whose DAC value does not exceed the held input. An input at zero gives 0x0000, mid-scale gives 0x8000, and full scale minus one LSB gives 0xFFFF.
- R5: Trials run MSB first. Right after the starting edge, `dac_code` is 0x8000. On each later edge, the bit under trial is kept when `cmp_keep` is 1 and cleared when it is 0, and the next lower bit is set for trial.
- R6: The output latch loads only on the edge where busy falls. A read during a conversion returns the previous result.
- R7: A fall of `start_n` while busy is high is ignored. It neither restarts nor lengthens the running conversion, and it does not change that conversion's result.
- R8: `db_en` is high exactly when `cs_n` and `rd_n` are both low, and `db` is high-impedance whenever `db_en` is low.
- R9: With `byte_hi` low, `db[15:0]` carries the full result, so its low byte is on lines 7..0. With `byte_hi` high, `db[7:0]` carries result bits 15..8 and `db[15:8]` is zero. The lane change needs no clock edge.
- R10: After reset, busy is low and the latched result is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; one bit is decided per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low conversion start |
| cs_n | input | 1 | Active-low select; qualifies start and read |
| rd_n | input | 1 | Active-low read enable for the data bus |
| byte_hi | input | 1 | Lane select: 0 gives the full word, 1 gives bits 15..8 on lines 7..0 |
| cmp_keep | input | 1 | Comparator: 1 when the DAC value does not exceed the held input |
| busy | output | 1 | High while a conversion runs |
| hold | output | 1 | High while the input is held (sample switch open) |
| dac_code | output | 16 | Trial code driven to the capacitor DAC |
| db_en | output | 1 | High while the data bus is driven |
| db | output | 16 | Tri-stated parallel result bus |

## Verification
A wrong step count in the sequencer shows up on `busy`. Busy falls one or more edges too early or too late, and the check at the 15th and 16th edge after the start finds it within one conversion. A wrong keep/clear decision or trial-bit order shows as a wrong code on `db` as soon as busy falls. Codes whose bit patterns differ, and the extreme codes, expose stuck or swapped bits. A latch that loads at the wrong moment is caught by reading the bus in the middle of a conversion. A wrong lane or enable decode shows on `db` and `db_en` at once, without a clock edge.

// File: rtl/sar_ctrl_pkg.sv
`timescale 1ns/1ps
package sar_ctrl_pkg;

    localparam int unsigned DEF_BITS = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic begin_conv;
        logic step;
        logic finish;
    } seq_ctl_t;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = DEF_BITS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_n,
    input  logic     cs_n,
    output logic     busy,
    output seq_ctl_t ctl
);
    localparam int unsigned CW = cnt_bits(BITS);
    localparam logic [CW-1:0] LAST_IDX = CW'(BITS - 1);

    conv_state_e   state;
    logic          start_q;
    logic [CW-1:0] left_q;
    logic          fall;
    logic          accept;

    always_comb begin
        fall            = start_q & ~start_n;
        accept          = fall & ~cs_n & (state == ST_IDLE);
        busy            = (state == ST_CONV) | accept;
        ctl.begin_conv  = accept;
        ctl.step        = (state == ST_CONV);
        ctl.finish      = (state == ST_CONV) && (left_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b1;
            state   <= ST_IDLE;
            left_q  <= '0;
        end else begin
            start_q <= start_n;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_CONV;
                        left_q <= LAST_IDX;
                    end
                end
                ST_CONV: begin
                    if (left_q == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic [CW:0] len_q;
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) len_q <= '0;
        else                         len_q <= len_q + 1'b1;
    end

    // R3
    conv_len_chk: assert property (@(posedge clk) disable iff (rst)
        len_q <= (CW+1)'(BITS));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));

    // R1
    cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cs_n) |=> (state == ST_IDLE));

endmodule

// File: rtl/sar_reg.sv
`timescale 1ns/1ps
module sar_reg
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_ctl_t        ctl,
    input  logic            cmp_keep,
    output logic [BITS-1:0] trial_code,
    output logic [BITS-1:0] resolved,
    output logic            last_trial
);
    localparam logic [BITS-1:0] MSB_ONE = {1'b1, {(BITS-1){1'b0}}};

    logic [BITS-1:0] code_q;
    logic [BITS-1:0] mask_q;
    logic [BITS-1:0] decided;

    // keep or clear the bit under trial, then put the next lower bit on trial
    always_comb begin
        decided    = cmp_keep ? code_q : (code_q & ~mask_q);
        resolved   = decided | (mask_q >> 1);
        trial_code = code_q;
        last_trial = mask_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (ctl.begin_conv) begin
            code_q <= MSB_ONE;
            mask_q <= MSB_ONE;
        end else if (ctl.step) begin
            code_q <= resolved;
            mask_q <= mask_q >> 1;
        end
    end

    // R5
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.begin_conv |=> (code_q == MSB_ONE));

    // R5
    trial_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_q));

endmodule

// File: rtl/sar_out.sv
`timescale 1ns/1ps
module sar_out
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] result_in,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            byte_hi,
    output logic            bus_en,
    output logic [BITS-1:0] bus_word
);
    localparam int unsigned HALF = BITS / 2;

    logic [BITS-1:0] result_q;

    always_ff @(posedge clk) begin
        if (rst)       result_q <= '0;
        else if (load) result_q <= result_in;
    end

    assign bus_en = ~cs_n & ~rd_n;

    for (genvar g = 0; g < HALF; g++) begin : g_lane
        assign bus_word[g]        = byte_hi ? result_q[g + HALF] : result_q[g];
        assign bus_word[g + HALF] = byte_hi ? 1'b0 : result_q[g + HALF];
    end

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(result_q));

endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_n,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            byte_hi,
    input  logic            cmp_keep,
    output logic            busy,
    output logic            hold,
    output logic [BITS-1:0] dac_code,
    output logic            db_en,
    output logic [BITS-1:0] db
);
    seq_ctl_t        ctl;
    logic [BITS-1:0] resolved;
    logic            last_trial;
    logic [BITS-1:0] bus_word;

    sar_seq #(.BITS(BITS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .cs_n    (cs_n),
        .busy    (busy),
        .ctl     (ctl)
    );

    sar_reg #(.BITS(BITS)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .cmp_keep   (cmp_keep),
        .trial_code (dac_code),
        .resolved   (resolved),
        .last_trial (last_trial)
    );

    sar_out #(.BITS(BITS)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.finish),
        .result_in (resolved),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .byte_hi   (byte_hi),
        .bus_en    (db_en),
        .bus_word  (bus_word)
    );

    assign hold = busy;
    assign db   = db_en ? bus_word : 'z;

    // R3
    finish_align_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> (ctl.finish == last_trial));

    // R2
    busy_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.begin_conv |-> busy);

endmodule

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
module sim_sar_conv_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        byte_hi = 1'b0;
    logic        cmp_keep;
    logic        busy, hold, db_en;
    logic [15:0] dac_code, db;
    logic [15:0] vin = 16'h0000;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] last_res = 16'h0000;

    always #4 clk = ~clk;

    sar_conv_ctrl u0 (
        .clk(clk), .rst(rst), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
        .byte_hi(byte_hi), .cmp_keep(cmp_keep), .busy(busy), .hold(hold),
        .dac_code(dac_code), .db_en(db_en), .db(db)
    );

    // comparator model: keep the trial bit when the DAC code is not above the input
    always_comb cmp_keep = (dac_code <= vin);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare the bus against the scoreboard when busy falls
    always @(negedge busy) begin
        if (!rst && exp_q.size() > 0) begin
            logic [15:0] e;
            #2;
            e = exp_q.pop_front();
            check(db == e, "R4 result code", {16'h0, db}, {16'h0, e});
            last_res = e;
        end
    end

    // driver: one conversion, optional second start while busy
    task automatic run_conv(input logic [15:0] v, input bit inject);
        @(negedge clk);
        start_n = 1'b1;
        vin = v;
        @(negedge clk);
        start_n = 1'b0;
        #1;
        check(busy == 1'b1 && hold == 1'b1, "R2 busy at start fall", {31'h0, busy}, 32'h1);
        exp_q.push_back(v);
        @(posedge clk);
        @(negedge clk);
        check(dac_code == 16'h8000, "R5 first trial", {16'h0, dac_code}, 32'h8000);
        start_n = 1'b1;
        for (int i = 1; i <= 15; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 5)
                check(db == last_res, "R6 read during conversion", {16'h0, db}, {16'h0, last_res});
            if (inject && i == 6) start_n = 1'b0;
        end
        check(busy == 1'b1, "R3 busy after 15 edges", {31'h0, busy}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R3 busy low after 16 edges", {31'h0, busy}, 32'h0);
        if (inject) begin
            #3;
            check(db == v, "R7 second start ignored", {16'h0, db}, {16'h0, v});
            check(busy == 1'b0, "R7 no restart", {31'h0, busy}, 32'h0);
        end
        start_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check(busy == 1'b0, "R10 busy after reset", {31'h0, busy}, 32'h0);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check(db_en == 1'b1 && db == 16'h0000, "R10 result after reset", {16'h0, db}, 32'h0);

        // R8 enable decode
        cs_n = 1'b1; rd_n = 1'b0; #1;
        check(db_en == 1'b0, "R8 cs high releases bus", {31'h0, db_en}, 32'h0);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check(db_en == 1'b0, "R8 rd high releases bus", {31'h0, db_en}, 32'h0);
        cs_n = 1'b1; rd_n = 1'b1; #1;
        check(db_en == 1'b0, "R8 both high releases bus", {31'h0, db_en}, 32'h0);

        // R1 start with select high
        @(negedge clk);
        vin = 16'h4321;
        start_n = 1'b0;
        #1;
        check(busy == 1'b0, "R1 start ignored while cs high", {31'h0, busy}, 32'h0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1 still idle", {31'h0, busy}, 32'h0);
        start_n = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check(db == 16'h0000, "R1 result unchanged", {16'h0, db}, 32'h0);

        run_conv(16'h0000, 1'b0);
        run_conv(16'hFFFF, 1'b0);
        run_conv(16'h8000, 1'b0);
        run_conv(16'h7FFF, 1'b0);
        run_conv(16'h1234, 1'b1);
        run_conv(16'hA5C3, 1'b0);

        // R9 byte lanes, no clock needed
        @(negedge clk);
        byte_hi = 1'b1; #1;
        check(db == 16'h00A5, "R9 high byte on low lines", {16'h0, db}, 32'h00A5);
        byte_hi = 1'b0; #1;
        check(db == 16'hA5C3, "R9 full word", {16'h0, db}, 32'hA5C3);
        check(db[7:0] == 8'hC3, "R9 low byte on low lines", {24'h0, db[7:0]}, 32'hC3);
        check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule